// File: doc/BRIEF.md
# Banked Register File with Exception Entry

This block holds the architectural register state of a 32-bit processor core and keeps it consistent across seven operating modes. The instruction path addresses registers by a 4-bit logical number (0 to 15, with 15 being the program counter). The block steers each logical number to the physical register that belongs to the current mode. Fast-interrupt mode has private copies of logical registers 8 to 12. Every exception mode has private copies of the stack register (13) and the link register (14). User and system mode share one bank. There are 31 physical general registers, one current status register and five saved status registers, one for each exception mode.

The core reads through two combinational read ports and writes through one write port, which takes effect at the clock edge. A pulse on `pc_step` advances the PC by 4. An exception request names one of seven causes. In a single cycle the block then copies the current status into the saved status register of the target mode and switches the mode field. It masks IRQ, and also FIQ for fast interrupts and reset. It writes the supplied return address into the link register of the target mode and loads the PC with the vector for that cause. All pins are plain control and data pins with no handshake: every request is taken in the cycle it is presented.

Top module: `bankreg_core`

## Requirements
- R1: During and after reset, every general register is zero. The current status reads 0x000000D3, which is supervisor mode with bits 7 (IRQ mask) and 6 (FIQ mask) set. The saved status seen in supervisor mode is zero.
- R2: The mode is bits [4:0] of the current status. The codes are 10000 user, 10001 fast interrupt, 10010 interrupt, 10011 supervisor, 10111 abort, 11011 undefined and 11111 system. Any other code selects the user bank.
- R3: A write with `wr_en` high lands at the clock edge. From the next cycle on, both read ports return it, and each port reads its own index independently.
- R4: In fast-interrupt mode, logical registers 8 to 12 map to a private bank. Logical 13 and 14 map to one private pair for each exception mode. User and system share registers 0 to 14. All modes share the PC (15).
- R5: On an exception, the saved status of the target mode receives the old current status. The mode field becomes the target mode and bit 7 is set. Bit 6 is also set for fast-interrupt and reset causes. Bits 31 to 8 and bit 5 are kept.
- R6: Causes are encoded as 0 reset, 1 undefined, 2 software interrupt, 3 prefetch abort, 4 data abort, 6 IRQ and 7 FIQ. The target modes are, in the same order, supervisor, undefined, supervisor, abort, abort, interrupt and fast interrupt. The link register of the target mode receives `exc_ret_addr`, and the PC receives the cause code times 4. Code 5 is not a request: that cycle behaves as if `exc_req` were low.
- R7: The saved-status output shows the saved status of the current mode, and reads zero in user, system or any unlisted mode.
- R8: `pc_step` adds 4 to the PC. A same-cycle write to logical register 15 takes precedence over the step.
- R9: An exception taken in a cycle discards that cycle's register write, status write and PC step.
- R10: `psr_wr_en` replaces the whole current status. Without a status write or an exception, the current status holds its value. A register write in the same cycle is steered by the mode in force before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical index for read port A |
| rd_a_data | output | DATA_W | Read port A data, combinational |
| rd_b_idx | input | 4 | Logical index for read port B |
| rd_b_data | output | DATA_W | Read port B data, combinational |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 4 | Logical index for the write |
| wr_data | input | DATA_W | Write data |
| pc_step | input | 1 | Advance PC by 4 |
| psr_wr_en | input | 1 | Replace current status |
| psr_wr_data | input | DATA_W | New current status value |
| cpsr_data | output | DATA_W | Current status |
| spsr_data | output | DATA_W | Saved status of the current mode, zero in user or system mode |
| exc_req | input | 1 | Exception entry request |
| exc_kind | input | 3 | Exception cause code |
| exc_ret_addr | input | DATA_W | Return address for the target link register |

## Verification
Exception entry can coincide with a general register write, a status write and a PC step in the same cycle. Its link-register and PC writes target the very locations that the general write may address. The random stream overlaps these operations freely. A directed cycle raises an abort together with a write to register 14, a PC step and a status write. The reference model drops all three of those operations and expects only the entry effects on every register of the new mode.

// File: rtl/bankreg_pkg.sv
`timescale 1ns/1ps
package bankreg_pkg;
  localparam int NLOG    = 16;
  localparam int NBANK   = 5;
  localparam int NFIQHI  = 5;
  localparam int NPHYS   = NLOG + NFIQHI + 2 * NBANK;
  localparam int PIDX_W  = $clog2(NPHYS);
  localparam int BANK_W  = $clog2(NBANK);
  localparam int FIQ_BASE = NLOG;
  localparam int SP_BASE  = FIQ_BASE + NFIQHI;
  localparam int LR_BASE  = SP_BASE + NBANK;
  localparam int PC_IDX   = NLOG - 1;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  typedef enum logic [2:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SWI   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_NONE  = 3'd5,
    EXC_IRQ   = 3'd6,
    EXC_FIQ   = 3'd7
  } exc_e;

  typedef struct packed {
    logic              banked;
    logic              fiq;
    logic [BANK_W-1:0] bank;
  } bank_sel_t;
endpackage

// File: rtl/bankreg_mode_dec.sv
`timescale 1ns/1ps
module bankreg_mode_dec
  import bankreg_pkg::*;
(
  input  logic [4:0] mode_code,
  output bank_sel_t  sel
);
  always_comb begin
    sel = '0;
    case (mode_code)
      MODE_FIQ: begin sel.banked = 1'b1; sel.fiq = 1'b1; sel.bank = BANK_W'(0); end
      MODE_IRQ: begin sel.banked = 1'b1; sel.bank = BANK_W'(1); end
      MODE_SVC: begin sel.banked = 1'b1; sel.bank = BANK_W'(2); end
      MODE_ABT: begin sel.banked = 1'b1; sel.bank = BANK_W'(3); end
      MODE_UND: begin sel.banked = 1'b1; sel.bank = BANK_W'(4); end
      default:  sel = '0;
    endcase
  end
endmodule

// File: rtl/bankreg_idx_map.sv
`timescale 1ns/1ps
module bankreg_idx_map
  import bankreg_pkg::*;
(
  input  logic [3:0]        lidx,
  input  bank_sel_t         sel,
  output logic [PIDX_W-1:0] pidx
);
  always_comb begin
    pidx = PIDX_W'(lidx);
    if (sel.fiq && lidx >= 4'd8 && lidx <= 4'd12)
      pidx = PIDX_W'(FIQ_BASE) + PIDX_W'(lidx - 4'd8);
    else if (sel.banked && lidx == 4'd13)
      pidx = PIDX_W'(SP_BASE) + PIDX_W'(sel.bank);
    else if (sel.banked && lidx == 4'd14)
      pidx = PIDX_W'(LR_BASE) + PIDX_W'(sel.bank);
  end
endmodule

// File: rtl/bankreg_entry.sv
`timescale 1ns/1ps
module bankreg_entry
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              exc_req,
  input  logic [2:0]        exc_kind,
  output logic              fire,
  output logic [4:0]        tgt_mode,
  output logic [BANK_W-1:0] tgt_bank,
  output logic              mask_fiq,
  output logic [DATA_W-1:0] vector
);
  always_comb begin
    fire     = exc_req;
    tgt_mode = MODE_SVC;
    tgt_bank = BANK_W'(2);
    mask_fiq = 1'b0;
    case (exc_kind)
      EXC_RESET: mask_fiq = 1'b1;
      EXC_UNDEF: begin tgt_mode = MODE_UND; tgt_bank = BANK_W'(4); end
      EXC_SWI:   ;
      EXC_PABT,
      EXC_DABT:  begin tgt_mode = MODE_ABT; tgt_bank = BANK_W'(3); end
      EXC_IRQ:   begin tgt_mode = MODE_IRQ; tgt_bank = BANK_W'(1); end
      EXC_FIQ:   begin tgt_mode = MODE_FIQ; tgt_bank = BANK_W'(0); mask_fiq = 1'b1; end
      default:   fire = 1'b0;
    endcase
    vector = DATA_W'({exc_kind, 2'b00});
  end
endmodule

// File: rtl/bankreg_core.sv
`timescale 1ns/1ps
module bankreg_core
  import bankreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pc_step,
  input  logic              psr_wr_en,
  input  logic [DATA_W-1:0] psr_wr_data,
  output logic [DATA_W-1:0] cpsr_data,
  output logic [DATA_W-1:0] spsr_data,
  input  logic              exc_req,
  input  logic [2:0]        exc_kind,
  input  logic [DATA_W-1:0] exc_ret_addr
);
  localparam int NPORT = 3;
  localparam logic [DATA_W-1:0] PSR_RESET = DATA_W'(8'hD3);
  localparam logic [DATA_W-1:0] PC_INC    = DATA_W'(4);

  logic [DATA_W-1:0] phys_q [NPHYS];
  logic [DATA_W-1:0] spsr_q [NBANK];
  logic [DATA_W-1:0] cpsr_q;

  bank_sel_t cur_sel;
  bankreg_mode_dec u_mode (.mode_code(cpsr_q[4:0]), .sel(cur_sel));

  logic [3:0]        port_lidx [NPORT];
  logic [PIDX_W-1:0] port_pidx [NPORT];
  assign port_lidx[0] = rd_a_idx;
  assign port_lidx[1] = rd_b_idx;
  assign port_lidx[2] = wr_idx;

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    bankreg_idx_map u_map (.lidx(port_lidx[g]), .sel(cur_sel), .pidx(port_pidx[g]));
  end

  logic              ex_fire;
  logic [4:0]        ex_mode;
  logic [BANK_W-1:0] ex_bank;
  logic              ex_mask_f;
  logic [DATA_W-1:0] ex_vec;
  bankreg_entry #(.DATA_W(DATA_W)) u_entry (
    .exc_req (exc_req),
    .exc_kind(exc_kind),
    .fire    (ex_fire),
    .tgt_mode(ex_mode),
    .tgt_bank(ex_bank),
    .mask_fiq(ex_mask_f),
    .vector  (ex_vec)
  );

  logic [PIDX_W-1:0] lr_pidx;
  assign lr_pidx = PIDX_W'(LR_BASE) + PIDX_W'(ex_bank);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) phys_q[i] <= '0;
    end else if (ex_fire) begin
      phys_q[lr_pidx] <= exc_ret_addr;
      phys_q[PC_IDX]  <= ex_vec;
    end else begin
      if (pc_step) phys_q[PC_IDX] <= phys_q[PC_IDX] + PC_INC;
      if (wr_en)   phys_q[port_pidx[2]] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpsr_q <= PSR_RESET;
      for (int b = 0; b < NBANK; b++) spsr_q[b] <= '0;
    end else if (ex_fire) begin
      spsr_q[ex_bank] <= cpsr_q;
      cpsr_q <= {cpsr_q[DATA_W-1:8], 1'b1, cpsr_q[6] | ex_mask_f, cpsr_q[5], ex_mode};
    end else if (psr_wr_en) begin
      cpsr_q <= psr_wr_data;
    end
  end

  assign rd_a_data = phys_q[port_pidx[0]];
  assign rd_b_data = phys_q[port_pidx[1]];
  assign cpsr_data = cpsr_q;
  assign spsr_data = cur_sel.banked ? spsr_q[cur_sel.bank] : '0;
endmodule

// File: rtl/bankreg_chk.sv
`timescale 1ns/1ps
module bankreg_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic              pc_step,
  input logic              psr_wr_en,
  input logic [DATA_W-1:0] cpsr_data,
  input logic [DATA_W-1:0] spsr_data,
  input logic              exc_req,
  input logic [2:0]        exc_kind
);
  logic taken;
  assign taken = exc_req && (exc_kind != 3'd5);

  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> cpsr_data[7]);

  a_r5_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (exc_kind == 3'd7 || exc_kind == 3'd0)) |=> cpsr_data[6]);

  a_r5_status_saved: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (spsr_data == $past(cpsr_data)));

  a_r6_vector_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> (rd_a_idx != 4'd15 || rd_a_data == DATA_W'({$past(exc_kind), 2'b00})));

  a_r10_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken && !psr_wr_en) |=> $stable(cpsr_data));

  a_r7_user_no_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (cpsr_data[4:0] == 5'b10000 || cpsr_data[4:0] == 5'b11111) |-> (spsr_data == '0));

  logic unused_ok;
  assign unused_ok = wr_en ^ pc_step;
endmodule

bind bankreg_core bankreg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .pc_step(pc_step), .psr_wr_en(psr_wr_en),
  .cpsr_data(cpsr_data), .spsr_data(spsr_data),
  .exc_req(exc_req), .exc_kind(exc_kind)
);

// File: tb/tb_bankreg_core.sv
`timescale 1ns/10ps
module tb_bankreg_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0;
  logic [31:0] cpsr_data, spsr_data, exc_ret_addr = '0;
  logic        wr_en = 1'b0, pc_step = 1'b0, psr_wr_en = 1'b0, exc_req = 1'b0;
  logic [2:0]  exc_kind = '0;

  always #2 clk = ~clk;

  bankreg_core #(.DATA_W(32)) dut (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] m_usr [16];
  logic [31:0] m_fiq [5];
  logic [31:0] m_r13 [5];
  logic [31:0] m_r14 [5];
  logic [31:0] m_spsr [5];
  logic [31:0] m_cpsr;

  function automatic int m_bank(input logic [4:0] c);
    case (c)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [4:0] m_target(input logic [2:0] k);
    case (k)
      3'd1:      return 5'b11011;
      3'd3, 3'd4: return 5'b10111;
      3'd6:      return 5'b10010;
      3'd7:      return 5'b10001;
      default:   return 5'b10011;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input int idx);
    int b = m_bank(m_cpsr[4:0]);
    if (b == 0 && idx >= 8 && idx <= 12) return m_fiq[idx-8];
    if (b >= 0 && idx == 13) return m_r13[b];
    if (b >= 0 && idx == 14) return m_r14[b];
    return m_usr[idx];
  endfunction

  task automatic m_write(input int idx, input logic [31:0] v);
    int b = m_bank(m_cpsr[4:0]);
    if (b == 0 && idx >= 8 && idx <= 12) m_fiq[idx-8] = v;
    else if (b >= 0 && idx == 13) m_r13[b] = v;
    else if (b >= 0 && idx == 14) m_r14[b] = v;
    else m_usr[idx] = v;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    int b = m_bank(m_cpsr[4:0]);
    check({tag, " cpsr"}, cpsr_data, m_cpsr);
    check({tag, " spsr R7"}, spsr_data, (b < 0) ? 32'h0 : m_spsr[b]);
    for (int i = 0; i < 16; i += 2) begin
      rd_a_idx = 4'(i);
      rd_b_idx = 4'(i + 1);
      #0.2;
      check({tag, " portA R4"}, rd_a_data, m_read(i));
      check({tag, " portB R3"}, rd_b_data, m_read(i + 1));
    end
  endtask

  task automatic apply(input string tag, input bit we, input logic [3:0] wi, input logic [31:0] wd,
                       input bit st, input bit pw, input logic [31:0] pd,
                       input bit ex, input logic [2:0] ek, input logic [31:0] ra);
    bit fire;
    logic [31:0] old_pc;
    wr_en = we; wr_idx = wi; wr_data = wd; pc_step = st;
    psr_wr_en = pw; psr_wr_data = pd;
    exc_req = ex; exc_kind = ek; exc_ret_addr = ra;
    @(posedge clk);
    #0.5;
    wr_en = 0; pc_step = 0; psr_wr_en = 0; exc_req = 0;
    fire = ex && (ek != 3'd5);
    if (fire) begin
      int tb_b = m_bank(m_target(ek));
      m_spsr[tb_b] = m_cpsr;
      m_cpsr = {m_cpsr[31:8], 1'b1, m_cpsr[6] | (ek == 3'd7 || ek == 3'd0), m_cpsr[5], m_target(ek)};
      m_r14[tb_b] = ra;
      m_usr[15] = {27'b0, ek, 2'b00};
    end else begin
      old_pc = m_usr[15];
      if (st) m_usr[15] = old_pc + 32'd4;
      if (we) m_write(int'(wi), wd);
      if (pw) m_cpsr = pd;
    end
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) m_usr[i] = '0;
    for (int i = 0; i < 5; i++) begin m_fiq[i] = '0; m_r13[i] = '0; m_r14[i] = '0; m_spsr[i] = '0; end
    m_cpsr = 32'h0000_00D3;
    repeat (3) @(posedge clk);
    #0.5;
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk);
    #0.5;
    check_all("R1 after reset");

    // R10: enter user mode through status write
    apply("R10 psr to usr", 0, 0, 0, 0, 1, 32'h0000_0010, 0, 0, 0);
    for (int i = 0; i < 15; i++)
      apply("R3 usr fill", 1, 4'(i), 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0);
    // R4: fast-interrupt bank
    apply("R2 psr to fiq", 0, 0, 0, 0, 1, 32'h0000_00D1, 0, 0, 0);
    for (int i = 8; i < 15; i++)
      apply("R4 fiq fill", 1, 4'(i), 32'hF000_0000 + i, 0, 0, 0, 0, 0, 0);
    apply("R4 back to usr", 0, 0, 0, 0, 1, 32'h0000_0010, 0, 0, 0);
    apply("R7 system shares usr", 0, 0, 0, 0, 1, 32'h0000_001F, 0, 0, 0);
    apply("R2 unlisted code acts as usr", 0, 0, 0, 0, 1, 32'h0000_0000, 0, 0, 0);
    apply("R10 write uses old mode", 1, 4'd13, 32'h1313_1313, 0, 1, 32'h0000_0012, 0, 0, 0);
    // R5/R6 software interrupt
    apply("R6 swi entry", 0, 0, 0, 0, 0, 0, 1, 3'd2, 32'h0000_1234);
    apply("R6 code 5 ignored", 0, 0, 0, 0, 0, 0, 1, 3'd5, 32'hDEAD_BEEF);
    // R9: abort entry with colliding write, step and status write
    apply("R9 entry beats write", 1, 4'd14, 32'h5555_5555, 1, 1, 32'h0000_001F, 1, 3'd3, 32'h0000_4444);
    // R8: PC step and write priority
    apply("R8 step", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R8 step", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    apply("R8 write over step", 1, 4'd15, 32'h0000_0100, 1, 0, 0, 0, 0, 0);
    apply("R5 fiq entry masks fiq", 0, 0, 0, 0, 0, 0, 1, 3'd7, 32'h0000_7777);
    apply("R5 reset-cause entry", 0, 0, 0, 0, 0, 0, 1, 3'd0, 32'h0000_0888);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] mc;
      logic [31:0] pd;
      case ($urandom % 8)
        0: mc = 5'b10000; 1: mc = 5'b10001; 2: mc = 5'b10010; 3: mc = 5'b10011;
        4: mc = 5'b10111; 5: mc = 5'b11011; 6: mc = 5'b11111; default: mc = 5'($urandom);
      endcase
      pd = {$urandom, 5'b0} | {27'b0, mc};
      apply("R3 R4 R9 random", ($urandom % 2) == 0, 4'($urandom), $urandom,
            ($urandom % 3) == 0, ($urandom % 5) == 0, pd,
            ($urandom % 6) == 0, 3'($urandom), $urandom);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule